// File: doc/BRIEF.md
# Host Coprocessor Message FIFO

This block sits between a host bus and an embedded coprocessor and carries short messages in both directions. Host words bound for the coprocessor go into an inbound queue. Words the coprocessor produces for the host go into an outbound queue. Both queues are reached through one host data address: a write there pushes the inbound queue, and a read there pops the outbound queue. A message is two 32-bit words. The host normally sends only when the inbound queue is empty. It writes the first word, checks the inbound not-full flag, and then writes the second word. To receive, it reads the data address once per word while the outbound not-empty flag is set.

The host also sees four other registers. A status register holds the queue flags and the interrupt flags. A control register holds the per-queue enables. A mailbox register is loaded by the coprocessor, and the host clears it by writing the idle pattern 0x0000F0F0. A third, one-way watch queue lets the coprocessor post 31-bit debug entries. Each read of the watch queue returns the entry with a valid bit in bit 31.

The host register map is: 0 data, 1 status (read only), 2 control, 3 mailbox, 4 watch queue (reading pops it). Host accesses are synchronous, and read data appears on `host_rdata` on the clock edge that follows the read request.

Top module: `hcm_msg_fifo`

## Requirements
- R1: After reset the status register reads 0x00060000, the control register reads 0, the mailbox reads 0x0000F0F0, and no queue holds data.
- R2: A host write to address 0 pushes the word into the inbound queue. The coprocessor sees the words on `cp_in_data` in write order while `cp_in_valid` is high, and each `cp_in_pop` pulse advances the queue by one word.
- R3: Each queue holds two words. A host write to a full inbound queue is dropped, and the queue contents stay unchanged.
- R4: A host read of address 0 pops the outbound queue. The words come out in the order the coprocessor pushed them.
- R5: A host read of address 0 while the outbound queue is empty returns 0 and leaves every queue unchanged.
- R6: The status bit positions are: 16 outbound not empty, 17 inbound not full, 18 outbound not full, 19 inbound not empty, 20 mailbox pending, 21 inbound interrupt, 22 outbound interrupt, 23 watch interrupt. All other bits read 0.
- R7: Control bit 16 is the outbound enable and bit 17 is the inbound enable. A control write updates bit 16 only when bit 24 of the written data is 1, and updates bit 17 only when bit 25 is 1. Bits 24 and 25 read back as 0.
- R8: The outbound interrupt is (outbound not empty AND outbound enable). The inbound interrupt is (inbound not empty AND inbound enable). `host_irq` is the OR of the outbound, mailbox and watch interrupts. `cp_irq` is the inbound interrupt. Each interrupt clears when its queue drains.
- R9: A `cp_mbox_we` pulse loads `cp_mbox_data` into the mailbox. The mailbox-pending flag is set whenever the mailbox differs from 0x0000F0F0. A host write of 0x0000F0F0 to address 3 clears the flag. A host write takes priority over a coprocessor write in the same cycle.
- R10: A host read of address 4 returns {1, entry} and pops the entry when the watch queue is not empty, and returns 0 when it is empty. The watch interrupt is set while the watch queue is not empty.
- R11: A coprocessor push to a full outbound queue is dropped, and `cp_out_full` is high while the outbound queue holds two words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write request |
| host_rd | input | 1 | Host read request |
| host_addr | input | 3 | Host register address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, valid the cycle after a read |
| host_irq | output | 1 | Host interrupt |
| cp_in_data | output | 32 | Head word of the inbound queue |
| cp_in_valid | output | 1 | Inbound queue not empty |
| cp_in_pop | input | 1 | Coprocessor consumes the inbound head word |
| cp_out_push | input | 1 | Coprocessor pushes an outbound word |
| cp_out_data | input | 32 | Outbound word |
| cp_out_full | output | 1 | Outbound queue full |
| cp_watch_push | input | 1 | Coprocessor pushes a watch entry |
| cp_watch_data | input | 31 | Watch entry |
| cp_mbox_we | input | 1 | Coprocessor mailbox write |
| cp_mbox_data | input | 32 | Coprocessor mailbox value |
| cp_irq | output | 1 | Coprocessor interrupt (inbound interrupt) |

## Verification
The assertions check four things on every cycle. A push into a full queue leaves its count unchanged, and a pop from an empty queue leaves it empty. An empty outbound read returns zero on the next cycle. A control write without the matching write-qualifier bit leaves its enable unchanged. Writing the idle pattern to the mailbox returns it to idle. Some behaviours only the bench scenarios can show: that words come out in the order they went in, that a word dropped at a full queue never appears later, the exact bit layout of the status and control registers, and how the interrupts follow the enables as the queues fill and drain.

// File: rtl/hcm_pkg.sv
package hcm_pkg;
   // host register addresses
   localparam logic [2:0] ADR_DATA  = 3'd0;
   localparam logic [2:0] ADR_STAT  = 3'd1;
   localparam logic [2:0] ADR_CTRL  = 3'd2;
   localparam logic [2:0] ADR_MBOX  = 3'd3;
   localparam logic [2:0] ADR_WATCH = 3'd4;

   // status bit positions
   localparam int ST_OUT_NE  = 16;
   localparam int ST_IN_NF   = 17;
   localparam int ST_OUT_NF  = 18;
   localparam int ST_IN_NE   = 19;
   localparam int ST_MB_INT  = 20;
   localparam int ST_IN_INT  = 21;
   localparam int ST_OUT_INT = 22;
   localparam int ST_WT_INT  = 23;

   // control bit positions
   localparam int CT_OUT_EN = 16;
   localparam int CT_IN_EN  = 17;
   localparam int CT_OUT_WQ = 24;
   localparam int CT_IN_WQ  = 25;

   localparam logic [31:0] MBOX_IDLE = 32'h0000_F0F0;

   typedef struct packed {
      logic out_en;
      logic in_en;
   } hcm_enables_t;
endpackage

// File: rtl/hcm_fifo.sv
module hcm_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int PW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("hcm_fifo: DEPTH must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("hcm_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_nx, rp_nx;
   logic [CW-1:0] cnt;
   logic          acc_push, acc_pop;

   assign acc_push = push & ~full;
   assign acc_pop  = pop & ~empty;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wp_nx = wp + 1'b1;
      assign rp_nx = rp + 1'b1;
   end else begin : g_wrap
      assign wp_nx = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      assign rp_nx = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (acc_push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (acc_push) wp <= wp_nx;
         if (acc_pop)  rp <= rp_nx;
         case ({acc_push, acc_pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign empty = (cnt == '0);
   assign full  = (cnt == CNT_FULL);
   assign rdata = empty ? '0 : mem[rp];

   // R3 / R11: a push into a full queue does not change its fill level
   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (push && full && !pop) |=> (cnt == $past(cnt)));
   // R5: a pop from an empty queue keeps it empty
   assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && empty && !push) |=> empty);
   // R3: the fill level never exceeds the depth
   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= CNT_FULL);
endmodule

// File: rtl/hcm_ctrl.sv
module hcm_ctrl
   import hcm_pkg::*;
(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [31:0]  wdata,
   output hcm_enables_t en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en <= '0;
      end else if (wr) begin
         if (wdata[CT_OUT_WQ]) en.out_en <= wdata[CT_OUT_EN];
         if (wdata[CT_IN_WQ])  en.in_en  <= wdata[CT_IN_EN];
      end
   end

   // R7: without its qualifier bit an enable keeps its value
   assert_out_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wdata[CT_OUT_WQ]) |=> $stable(en.out_en));
   assert_in_qual_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !wdata[CT_IN_WQ]) |=> $stable(en.in_en));
endmodule

// File: rtl/hcm_mailbox.sv
module hcm_mailbox
   import hcm_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_we,
   input  logic [31:0] host_data,
   input  logic        cp_we,
   input  logic [31:0] cp_data,
   output logic [31:0] mbox,
   output logic        pending
);
   always_ff @(posedge clk) begin
      if (!rst_n)       mbox <= MBOX_IDLE;
      else if (host_we) mbox <= host_data;
      else if (cp_we)   mbox <= cp_data;
   end

   assign pending = (mbox != MBOX_IDLE);

   // R9: the host idle write wins and clears the pending flag
   assert_mbox_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (host_we && host_data == MBOX_IDLE) |=> !pending);
endmodule

// File: rtl/hcm_msg_fifo.sv
module hcm_msg_fifo
   import hcm_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int IN_DEPTH    = 2,
   parameter int OUT_DEPTH   = 2,
   parameter int WATCH_DEPTH = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic              host_rd,
   input  logic [2:0]        host_addr,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] host_rdata,
   output logic              host_irq,
   output logic [DATA_W-1:0] cp_in_data,
   output logic              cp_in_valid,
   input  logic              cp_in_pop,
   input  logic              cp_out_push,
   input  logic [DATA_W-1:0] cp_out_data,
   output logic              cp_out_full,
   input  logic              cp_watch_push,
   input  logic [DATA_W-2:0] cp_watch_data,
   input  logic              cp_mbox_we,
   input  logic [DATA_W-1:0] cp_mbox_data,
   output logic              cp_irq
);
   localparam int WW = DATA_W - 1;

   if (DATA_W != 32) begin : g_bad_width
      $error("hcm_msg_fifo: register layout needs DATA_W == 32");
   end

   logic              in_push, out_pop, w_pop;
   logic              in_empty, in_full, out_empty, out_full, w_empty, w_full;
   logic [DATA_W-1:0] out_head, mbox;
   logic [WW-1:0]     w_head;
   logic              mb_pend, in_int, out_int, w_int;
   hcm_enables_t      en;
   logic [31:0]       status, ctrl_rb;

   assign in_push = host_wr && (host_addr == ADR_DATA);
   assign out_pop = host_rd && (host_addr == ADR_DATA);
   assign w_pop   = host_rd && (host_addr == ADR_WATCH);

   hcm_fifo #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_in_q (
      .clk(clk), .rst_n(rst_n), .push(in_push), .wdata(host_wdata),
      .pop(cp_in_pop), .rdata(cp_in_data), .empty(in_empty), .full(in_full));

   hcm_fifo #(.W(DATA_W), .DEPTH(OUT_DEPTH)) u_out_q (
      .clk(clk), .rst_n(rst_n), .push(cp_out_push), .wdata(cp_out_data),
      .pop(out_pop), .rdata(out_head), .empty(out_empty), .full(out_full));

   hcm_fifo #(.W(WW), .DEPTH(WATCH_DEPTH)) u_watch_q (
      .clk(clk), .rst_n(rst_n), .push(cp_watch_push), .wdata(cp_watch_data),
      .pop(w_pop), .rdata(w_head), .empty(w_empty), .full(w_full));

   hcm_ctrl u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr(host_wr && (host_addr == ADR_CTRL)),
      .wdata(host_wdata), .en(en));

   hcm_mailbox u_mbox (
      .clk(clk), .rst_n(rst_n),
      .host_we(host_wr && (host_addr == ADR_MBOX)), .host_data(host_wdata),
      .cp_we(cp_mbox_we), .cp_data(cp_mbox_data),
      .mbox(mbox), .pending(mb_pend));

   assign in_int  = ~in_empty & en.in_en;
   assign out_int = ~out_empty & en.out_en;
   assign w_int   = ~w_empty;

   always_comb begin
      status             = '0;
      status[ST_OUT_NE]  = ~out_empty;
      status[ST_IN_NF]   = ~in_full;
      status[ST_OUT_NF]  = ~out_full;
      status[ST_IN_NE]   = ~in_empty;
      status[ST_MB_INT]  = mb_pend;
      status[ST_IN_INT]  = in_int;
      status[ST_OUT_INT] = out_int;
      status[ST_WT_INT]  = w_int;
      ctrl_rb            = '0;
      ctrl_rb[CT_OUT_EN] = en.out_en;
      ctrl_rb[CT_IN_EN]  = en.in_en;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         host_rdata <= '0;
      end else if (host_rd) begin
         case (host_addr)
            ADR_DATA:  host_rdata <= out_head;
            ADR_STAT:  host_rdata <= status;
            ADR_CTRL:  host_rdata <= ctrl_rb;
            ADR_MBOX:  host_rdata <= mbox;
            ADR_WATCH: host_rdata <= w_empty ? '0 : {1'b1, w_head};
            default:   host_rdata <= '0;
         endcase
      end
   end

   assign cp_in_valid = ~in_empty;
   assign cp_out_full = out_full;
   assign host_irq    = out_int | mb_pend | w_int;
   assign cp_irq      = in_int;

   // R5: an empty outbound read yields zero on the following cycle
   assert_empty_read_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_pop && out_empty) |=> (host_rdata == '0));
   // R10: an empty watch read yields zero on the following cycle
   assert_watch_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (w_pop && w_empty) |=> (host_rdata == '0));
endmodule

// File: tb/hcm_msg_fifo_tb.sv
module hcm_msg_fifo_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NTBL = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 1'b0, host_rd = 1'b0;
   logic [2:0]  host_addr = '0;
   logic [31:0] host_wdata = '0;
   logic [31:0] host_rdata;
   logic        host_irq;
   logic [31:0] cp_in_data;
   logic        cp_in_valid;
   logic        cp_in_pop = 1'b0;
   logic        cp_out_push = 1'b0;
   logic [31:0] cp_out_data = '0;
   logic        cp_out_full;
   logic        cp_watch_push = 1'b0;
   logic [30:0] cp_watch_data = '0;
   logic        cp_mbox_we = 1'b0;
   logic [31:0] cp_mbox_data = '0;
   logic        cp_irq;

   int tests = 0;
   int fails = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   hcm_msg_fifo u_dut (
      .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
      .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .host_irq(host_irq), .cp_in_data(cp_in_data), .cp_in_valid(cp_in_valid),
      .cp_in_pop(cp_in_pop), .cp_out_push(cp_out_push), .cp_out_data(cp_out_data),
      .cp_out_full(cp_out_full), .cp_watch_push(cp_watch_push),
      .cp_watch_data(cp_watch_data), .cp_mbox_we(cp_mbox_we),
      .cp_mbox_data(cp_mbox_data), .cp_irq(cp_irq));

   // row: {req[71:68], is_read[67], addr[66:64], wdata[63:32], expected[31:0]}
   localparam logic [71:0] TBL [NTBL] = '{
      {4'd1,  1'b1, 3'd1, 32'h0, 32'h0006_0000},           // R1 R6 reset status
      {4'd1,  1'b1, 3'd3, 32'h0, 32'h0000_F0F0},           // R1 mailbox idle
      {4'd1,  1'b1, 3'd2, 32'h0, 32'h0000_0000},           // R1 control cleared
      {4'd7,  1'b0, 3'd2, 32'h0303_0000, 32'h0},           // R7 set both enables
      {4'd7,  1'b1, 3'd2, 32'h0, 32'h0003_0000},           // R7 readback
      {4'd7,  1'b0, 3'd2, 32'h0000_0000, 32'h0},           // R7 unqualified write
      {4'd7,  1'b1, 3'd2, 32'h0, 32'h0003_0000},           // R7 unchanged
      {4'd2,  1'b0, 3'd0, 32'h1111_1111, 32'h0},           // R2 first word
      {4'd8,  1'b1, 3'd1, 32'h0, 32'h002E_0000},           // R8 R6 inbound int
      {4'd2,  1'b0, 3'd0, 32'h2222_2222, 32'h0},           // R2 second word
      {4'd3,  1'b1, 3'd1, 32'h0, 32'h002C_0000},           // R3 inbound full
      {4'd3,  1'b0, 3'd0, 32'h3333_3333, 32'h0},           // R3 dropped word
      {4'd5,  1'b1, 3'd0, 32'h0, 32'h0000_0000}            // R5 empty outbound read
   };

   task automatic chk(input int req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL R%0d: actual %08h expected %08h", req, act, exp);
      end
   endtask

   task automatic hwr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      host_wr = 1'b1; host_addr = a; host_wdata = d;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic hrd(input logic [2:0] a, output logic [31:0] d);
      @(negedge clk);
      host_rd = 1'b1; host_addr = a;
      @(negedge clk);
      host_rd = 1'b0;
      d = host_rdata;
   endtask

   task automatic cp_pop();
      @(negedge clk); cp_in_pop = 1'b1;
      @(negedge clk); cp_in_pop = 1'b0;
   endtask

   task automatic cp_push(input logic [31:0] d);
      @(negedge clk); cp_out_push = 1'b1; cp_out_data = d;
      @(negedge clk); cp_out_push = 1'b0;
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL R0: watchdog actual running expected finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [31:0] r;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(1, {31'd0, cp_in_valid}, 32'd0);   // R1 no inbound data
      chk(1, {31'd0, host_irq}, 32'd0);      // R1

      for (int i = 0; i < NTBL; i++) begin
         if (TBL[i][67]) begin
            hrd(TBL[i][66:64], r);
            chk(int'(TBL[i][71:68]), r, TBL[i][31:0]);
         end else begin
            hwr(TBL[i][66:64], TBL[i][63:32]);
         end
      end

      // R2 R3 R8: coprocessor drains in order, dropped word never appears
      chk(2, {31'd0, cp_in_valid}, 32'd1);
      chk(8, {31'd0, cp_irq}, 32'd1);
      chk(2, cp_in_data, 32'h1111_1111);
      cp_pop();
      chk(2, cp_in_data, 32'h2222_2222);
      cp_pop();
      chk(3, {31'd0, cp_in_valid}, 32'd0);
      chk(8, {31'd0, cp_irq}, 32'd0);
      hrd(3'd1, r);
      chk(8, r, 32'h0006_0000);

      // R11 R4 R6 R8: outbound fill, overflow, ordered drain
      cp_push(32'hAAAA_0001);
      cp_push(32'hAAAA_0002);
      chk(11, {31'd0, cp_out_full}, 32'd1);
      cp_push(32'hAAAA_0003);
      chk(8, {31'd0, host_irq}, 32'd1);
      hrd(3'd1, r);
      chk(6, r, 32'h0043_0000);
      hrd(3'd0, r);
      chk(4, r, 32'hAAAA_0001);
      hrd(3'd0, r);
      chk(4, r, 32'hAAAA_0002);
      hrd(3'd0, r);
      chk(11, r, 32'h0000_0000);
      chk(8, {31'd0, host_irq}, 32'd0);

      // R9: mailbox pending and clear
      @(negedge clk); cp_mbox_we = 1'b1; cp_mbox_data = 32'h0000_1234;
      @(negedge clk); cp_mbox_we = 1'b0;
      hrd(3'd1, r);
      chk(9, r, 32'h0016_0000);
      chk(9, {31'd0, host_irq}, 32'd1);
      hrd(3'd3, r);
      chk(9, r, 32'h0000_1234);
      hwr(3'd3, 32'h0000_F0F0);
      hrd(3'd1, r);
      chk(9, r, 32'h0006_0000);

      // R10: watch queue
      @(negedge clk); cp_watch_push = 1'b1; cp_watch_data = 31'h0ABC_DEF1;
      @(negedge clk); cp_watch_push = 1'b0;
      hrd(3'd1, r);
      chk(10, r, 32'h0086_0000);
      hrd(3'd4, r);
      chk(10, r, 32'h8ABC_DEF1);
      hrd(3'd4, r);
      chk(10, r, 32'h0000_0000);

      // R7 R8: outbound enable off masks the outbound interrupt
      hwr(3'd2, 32'h0100_0000);
      hrd(3'd2, r);
      chk(7, r, 32'h0002_0000);
      cp_push(32'hBBBB_0001);
      hrd(3'd1, r);
      chk(8, r, 32'h0007_0000);
      chk(8, {31'd0, host_irq}, 32'd0);
      hrd(3'd0, r);
      chk(4, r, 32'hBBBB_0001);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule